// File: doc/BRIEF.md
# Four-Channel Double-Buffered DAC Serial Front End

This block is the digital front end of a four-channel converter with two register banks per channel. A 16-bit serial word enters most-significant bit first while the active-low select is held low. When the select returns high, the word's data code is written into one of four input registers. A two-bit channel field in the word chooses the register. A level-sensitive, active-low load input copies all four input registers into the converter registers that drive the analog stage. While the load input is held low, the converter registers follow the input registers continuously.

The serial clock, select, serial data, load and shutdown pins are brought into a faster system clock through a two-stage synchronizer. All edge detection runs in that system clock domain. An asynchronous active-low clear zeroes both register banks and leaves the serial shift register as it is. The shutdown input only drives a flag output. It never disturbs stored codes.

Top module: `qdac_front`

## Requirements
- R1: After system reset, every converter code output is zero and the shutdown flag is low.
- R2: While select is low, each rising edge of the serial clock shifts one data bit into the 16-bit shift register, most-significant bit first.
- R3: While select is high, serial clock edges are ignored and the shift register keeps its contents.
- R4: On a rising edge of select, bits [7:0] of the shift register are written into the input register of the channel given by bits [15:14], where 0 is channel A (output bits [7:0]) and 3 is channel D (output bits [31:24]). Bits [13:8] have no effect.
- R5: A rising edge of select after fewer than 16 serial clock edges transfers whatever the shift register holds at that moment.
- R6: While the load input is high, the converter code outputs do not change, whatever writes reach the input registers.
- R7: While the load input is low, all four converter registers follow their input registers together, so a write reaches its output without a further strobe. A short low pulse copies all four at once.
- R8: A low level on the clear input forces every input register and every converter register to zero at once, without waiting for a clock edge.
- R9: The clear input does not change the shift register, so a word interrupted by a clear completes correctly afterwards.
- R10: The shutdown flag follows the shutdown input after synchronization, and shutdown leaves the converter codes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ser_clk | input | 1 | Serial clock; data is shifted on its rising edge |
| ser_sel_n | input | 1 | Active-low select; its rising edge triggers the transfer |
| ser_data | input | 1 | Serial data, MSB first |
| load_n | input | 1 | Active-low, level-sensitive load of the converter registers |
| clear_n | input | 1 | Asynchronous active-low clear of both register banks |
| shutdown_in | input | 1 | Shutdown request |
| dac_code | output | 32 | Four 8-bit converter codes, channel A in the low byte |
| shutdown_out | output | 1 | Synchronized shutdown flag |

## Verification
If the shift register is corrupted, the wrong code or the wrong channel appears at the outputs. This shows in the cycles after the next select rising edge when load is held low, or after the next load pulse when it is not. A bad input register bank is hidden while load is high and appears on the next load pulse. For that reason the sweep pulses load after every write and checks all four channels, not only the channel that was addressed. Lost shift register state during a clear shows up only when the interrupted word completes, so that case is checked from the word that finishes after the clear.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int WORD_W_DEF = 16;
    localparam int ADDR_W_DEF = 2;
    localparam int DATA_W_DEF = 8;
    localparam int NCH_DEF    = 4;
    localparam int SYNC_DEF   = 2;

    // index of each pin within the synchronizer vector
    localparam int PIN_SCLK = 0;
    localparam int PIN_SDI  = 1;
    localparam int PIN_CSN  = 2;
    localparam int PIN_LDN  = 3;
    localparam int PIN_SHDN = 4;
    localparam int PIN_CNT  = 5;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic              csn_s,
    output logic [WORD_W-1:0] word,
    output logic              xfer
);
    typedef struct packed {
        logic              sclk_prev;
        logic              csn_prev;
        logic [WORD_W-1:0] sreg;
    } shf_t;

    shf_t st_d, st_q;
    logic sclk_rise;
    logic csn_rise;

    always_comb begin
        sclk_rise = sclk_s & ~st_q.sclk_prev;
        csn_rise  = csn_s & ~st_q.csn_prev;
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.csn_prev  = csn_s;
        if (sclk_rise && !csn_s) begin
            st_d.sreg = {st_q.sreg[WORD_W-2:0], sdi_s};
        end
    end

    // only the system reset touches this register; the bank clear does not
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk_prev <= 1'b0;
            st_q.csn_prev  <= 1'b1;
            st_q.sreg      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.sreg;
    assign xfer = csn_rise;
endmodule

// File: rtl/qdac_banks.sv
module qdac_banks #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8,
    parameter int NCH    = 4
) (
    input  logic                     clk,
    input  logic                     bank_rst_n,
    input  logic [WORD_W-1:0]        word,
    input  logic                     xfer,
    input  logic                     load_s_n,
    output logic [NCH*DATA_W-1:0]    in_flat,
    output logic [NCH*DATA_W-1:0]    dac_flat
);
    typedef struct packed {
        logic [NCH-1:0][DATA_W-1:0] inr;
        logic [NCH-1:0][DATA_W-1:0] dac;
    } bank_t;

    bank_t bk_d, bk_q;
    logic [ADDR_W-1:0] sel;
    logic [DATA_W-1:0] code;

    assign sel  = word[WORD_W-1 -: ADDR_W];
    assign code = word[DATA_W-1:0];

    always_comb begin
        bk_d = bk_q;
        for (int c = 0; c < NCH; c++) begin
            if (xfer && (int'(sel) == c)) bk_d.inr[c] = code;
        end
        if (!load_s_n) bk_d.dac = bk_d.inr;
    end

    always_ff @(posedge clk or negedge bank_rst_n) begin
        if (!bank_rst_n) begin
            bk_q <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_flat
        assign in_flat[c*DATA_W +: DATA_W]  = bk_q.inr[c];
        assign dac_flat[c*DATA_W +: DATA_W] = bk_q.dac[c];
    end
endmodule

// File: rtl/qdac_front.sv
module qdac_front
    import qdac_pkg::*;
#(
    parameter int WORD_W = WORD_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int NCH    = NCH_DEF,
    parameter int SYNC_N = SYNC_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_clk,
    input  logic                  ser_sel_n,
    input  logic                  ser_data,
    input  logic                  load_n,
    input  logic                  clear_n,
    input  logic                  shutdown_in,
    output logic [NCH*DATA_W-1:0] dac_code,
    output logic                  shutdown_out
);
    localparam logic [PIN_CNT-1:0] SYNC_RST = PIN_CNT'((1 << PIN_CSN) | (1 << PIN_LDN));

    logic [PIN_CNT-1:0]    pins_raw, pins_s;
    logic                  csn_s, load_s_n;
    logic [WORD_W-1:0]     sreg;
    logic                  xfer;
    logic                  bank_rst_n;
    logic [NCH*DATA_W-1:0] in_flat;

    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_SCLK] = ser_clk;
        pins_raw[PIN_SDI]  = ser_data;
        pins_raw[PIN_CSN]  = ser_sel_n;
        pins_raw[PIN_LDN]  = load_n;
        pins_raw[PIN_SHDN] = shutdown_in;
    end

    qdac_sync #(.W(PIN_CNT), .STAGES(SYNC_N), .RST_VAL(SYNC_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s)
    );

    assign csn_s    = pins_s[PIN_CSN];
    assign load_s_n = pins_s[PIN_LDN];

    qdac_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .sclk_s(pins_s[PIN_SCLK]),
        .sdi_s (pins_s[PIN_SDI]),
        .csn_s (csn_s),
        .word  (sreg),
        .xfer  (xfer)
    );

    assign bank_rst_n = rst_n & clear_n;

    qdac_banks #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH)) u_banks (
        .clk       (clk),
        .bank_rst_n(bank_rst_n),
        .word      (sreg),
        .xfer      (xfer),
        .load_s_n  (load_s_n),
        .in_flat   (in_flat),
        .dac_flat  (dac_code)
    );

    assign shutdown_out = pins_s[PIN_SHDN];
endmodule

// File: rtl/qdac_chk.sv
module qdac_chk #(
    parameter int WORD_W = 16,
    parameter int NBITS  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_n,
    input logic              csn_s,
    input logic              load_s_n,
    input logic              xfer,
    input logic [WORD_W-1:0] sreg,
    input logic [NBITS-1:0]  in_flat,
    input logic [NBITS-1:0]  dac_code
);
    // R3
    sel_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_s && $past(csn_s)) |=> $stable(sreg));

    // R6
    load_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !clear_n)
        load_s_n |=> $stable(dac_code));

    // R7
    load_low_follow_chk: assert property (@(posedge clk) disable iff (!rst_n || !clear_n)
        !load_s_n |=> (dac_code == in_flat));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n |-> (dac_code == '0 && in_flat == '0));

    // R9
    clear_keeps_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_n && csn_s) |=> $stable(sreg));

    // R4
    xfer_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> !xfer);
endmodule

bind qdac_front qdac_chk #(.WORD_W(WORD_W), .NBITS(NCH*DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_n (clear_n),
    .csn_s   (csn_s),
    .load_s_n(load_s_n),
    .xfer    (xfer),
    .sreg    (sreg),
    .in_flat (in_flat),
    .dac_code(dac_code)
);

// File: tb/qdac_front_bench.sv
`timescale 1ns/1ps
module qdac_front_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_sel_n = 1'b1;
    logic        ser_data = 1'b0;
    logic        load_n = 1'b1;
    logic        clear_n = 1'b1;
    logic        shutdown_in = 1'b0;
    logic [31:0] dac_code;
    logic        shutdown_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] exp_sr = '0;
    logic [7:0]  exp_in  [4];
    logic [7:0]  exp_dac [4];
    bit          load_held = 1'b0;

    always #4 clk = ~clk;

    qdac_front u_qdac_front (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
        .ser_data(ser_data), .load_n(load_n), .clear_n(clear_n),
        .shutdown_in(shutdown_in), .dac_code(dac_code), .shutdown_out(shutdown_out)
    );

    function automatic logic [31:0] pack_exp();
        return {exp_dac[3], exp_dac[2], exp_dac[1], exp_dac[0]};
    endfunction

    task automatic wait_cy(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sel_low();
        ser_sel_n = 1'b0;
        wait_cy(4);
    endtask

    task automatic send_bit(logic b);
        ser_data = b;
        ser_clk  = 1'b0;
        wait_cy(4);
        ser_clk  = 1'b1;
        wait_cy(4);
        if (!ser_sel_n) exp_sr = {exp_sr[14:0], b};
    endtask

    task automatic sel_high();
        ser_clk   = 1'b0;
        ser_sel_n = 1'b1;
        wait_cy(6);
        exp_in[exp_sr[15:14]] = exp_sr[7:0];
        if (load_held) for (int c = 0; c < 4; c++) exp_dac[c] = exp_in[c];
    endtask

    task automatic send_word(logic [15:0] w);
        sel_low();
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
        sel_high();
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        wait_cy(4);
        load_n = 1'b1;
        wait_cy(4);
        for (int c = 0; c < 4; c++) exp_dac[c] = exp_in[c];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin exp_in[c] = '0; exp_dac[c] = '0; end
        wait_cy(3);
        rst_n = 1'b1;
        wait_cy(3);
        // R1 reset state
        chk("R1 codes", dac_code, 32'h0);
        chk("R1 shutdown", {31'h0, shutdown_out}, 32'h0);

        // R4 R6: sweep every channel and several codes, load high then pulsed
        for (int k = 0; k < 6; k++) begin
            for (int a = 0; a < 4; a++) begin
                logic [7:0]  d;
                logic [5:0]  ctl;
                d   = 8'((k * 53 + a * 17 + 3) & 255);
                ctl = 6'((k * 11 + a * 7) & 63);
                if (k == 0) d = 8'hFF;
                send_word({2'(a), ctl, d});
                chk("R6 hold while load high", dac_code, pack_exp());
                pulse_load();
                chk("R4 R7 write then load pulse", dac_code, pack_exp());
            end
        end

        // R7: load held low, writes pass straight through
        load_n = 1'b0;
        load_held = 1'b1;
        wait_cy(4);
        for (int a = 0; a < 4; a++) begin
            send_word({2'(3 - a), 6'h2A, 8'(8'hA0 + a * 5)});
            chk("R7 transparent load", dac_code, pack_exp());
        end
        load_n = 1'b1;
        load_held = 1'b0;
        wait_cy(4);

        // R3: clock toggles with select high are ignored
        for (int i = 0; i < 5; i++) send_bit(1'(i & 1));
        sel_low();
        sel_high();
        pulse_load();
        chk("R3 idle clocks ignored", dac_code, pack_exp());

        // R5: partial word of 5 bits
        sel_low();
        for (int i = 0; i < 5; i++) send_bit(1'((i + 1) & 1));
        sel_high();
        pulse_load();
        chk("R5 partial word", dac_code, pack_exp());

        // R8 R9: clear in the middle of a word
        sel_low();
        for (int i = 0; i < 8; i++) send_bit(1'((8'b01000000 >> (7 - i)) & 1));
        clear_n = 1'b0;
        wait_cy(1);
        for (int c = 0; c < 4; c++) begin exp_in[c] = '0; exp_dac[c] = '0; end
        chk("R8 clear zeroes codes", dac_code, 32'h0);
        clear_n = 1'b1;
        wait_cy(2);
        pulse_load();
        chk("R8 clear zeroes input bank", dac_code, 32'h0);
        for (int i = 0; i < 8; i++) send_bit(1'((8'h3C >> (7 - i)) & 1));
        sel_high();
        pulse_load();
        chk("R9 word completes after clear", dac_code, pack_exp());
        chk("R9 expected channel B code", dac_code, 32'h00003C00);

        // R10: shutdown flag, codes untouched
        shutdown_in = 1'b1;
        wait_cy(4);
        chk("R10 shutdown flag high", {31'h0, shutdown_out}, 32'h1);
        chk("R10 codes kept in shutdown", dac_code, pack_exp());
        shutdown_in = 1'b0;
        wait_cy(4);
        chk("R10 shutdown flag low", {31'h0, shutdown_out}, 32'h0);
        chk("R2 R10 codes kept after shutdown", dac_code, pack_exp());

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule